// File: doc/BRIEF.md
# MIDI Note Byte Capture Controller

This block sits between a serial receiver and the note logic of a MIDI interface. The receiver offers one 8-bit byte at a time together with a level-style ready flag. That flag stays high until the block clears it. The block takes the byte into a holding register and returns a clear strobe that is exactly one clock wide. It then waits until the flag has been seen low before it accepts another byte, so a flag that the receiver drops late never yields a second strobe.

Each accepted byte moves a small message parser forward by exactly one step. The parser expects a status byte, then a key number, then a velocity. Only note-on and note-off channel messages are decoded. When the velocity arrives, the block presents a completed note event for one cycle, with its on/off sense, channel, key and velocity. A note-on with zero velocity is reported as a note-off. A status byte that arrives in the middle of a message restarts parsing from that byte. Any other status byte parks the parser until the next note status.

Top module: `midi_capture_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, and in the cycle after it, `ready_clr` and `ev_valid` are 0. Reset is synchronous and active high. It returns the parser to idle and re-arms the handshake.
- R2: If the block is armed and `rx_ready` is 1 at a rising edge, the block captures `rx_byte`. `ready_clr` is then 1 for exactly the one cycle after that edge.
- R3: After a strobe, no further strobe occurs while `rx_ready` stays high, however many cycles it stays high. The block re-arms at the first rising edge where it sees `rx_ready` low.
- R4: The parser advances once per accepted byte, in the order status, key, velocity. On the velocity byte, `ev_valid` is 1 for exactly the one cycle after the strobe cycle. In that cycle `ev_key` and `ev_vel` carry bits 6:0 of the key and velocity bytes.
- R5: A status byte has bit 7 set. Upper nibble 0x9 is note-on (`ev_on` = 1) and upper nibble 0x8 is note-off (`ev_on` = 0). The lower nibble is reported on `ev_chan`.
- R6: A note-on whose velocity is 0 is reported with `ev_on` = 0.
- R7: A byte with bit 7 set that arrives while a key or velocity is expected abandons the current message, and parsing restarts from that status byte.
- R8: A status byte other than 0x8n or 0x9n returns the parser to idle. The data bytes that follow it produce no event.
- R9: Data bytes (bit 7 clear) that arrive while the parser is idle are ignored and produce no event.
- R10: A reset in the middle of a message discards the message. If `rx_ready` is held high across reset, a strobe follows on the first edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge only |
| rst | input | 1 | Synchronous active-high reset |
| rx_byte | input | 8 | Byte offered by the receiver |
| rx_ready | input | 1 | Level flag, high while a byte waits |
| ready_clr | output | 1 | One-cycle strobe that clears the receiver flag |
| ev_valid | output | 1 | One-cycle completed note event |
| ev_on | output | 1 | 1 = note-on, 0 = note-off |
| ev_chan | output | 4 | Channel of the event |
| ev_key | output | 7 | Key number of the event |
| ev_vel | output | 7 | Velocity of the event |

## Verification
The handshake is tried with the ready flag held high for zero to three extra cycles after each strobe. This separates a correct single strobe from a strobe that re-fires, and from an early re-arm. Complete messages are swept over all sixteen channels, both commands and a spread of keys and velocities, including zero velocity. This shows whether status and data bytes reach the right fields and whether a zero-velocity note-on is folded into a note-off. Further streams cover a status byte in the middle of a message, foreign status bytes followed by data, stray data bytes in idle, and a reset in the middle of a message with the flag held high. These tell the restart, park and discard paths apart from plain advancing.

// File: rtl/midi_cap_pkg.sv
package midi_cap_pkg;

  localparam int BYTE_W = 8;
  localparam int DATA_W = BYTE_W - 1;
  localparam int CHAN_W = 4;
  localparam logic [3:0] CMD_NOTE_ON  = 4'h9;
  localparam logic [3:0] CMD_NOTE_OFF = 4'h8;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_KEY  = 2'd1,
    PS_VEL  = 2'd2
  } parse_state_t;

  function automatic logic is_status(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1];
  endfunction

  function automatic logic is_note_cmd(input logic [BYTE_W-1:0] b);
    return (b[BYTE_W-1 -: 4] == CMD_NOTE_ON) || (b[BYTE_W-1 -: 4] == CMD_NOTE_OFF);
  endfunction

  function automatic logic cmd_is_on(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1 -: 4] == CMD_NOTE_ON;
  endfunction

  function automatic logic sounding(input logic on_cmd, input logic [DATA_W-1:0] vel);
    return on_cmd && (vel != '0);
  endfunction

endpackage

// File: rtl/mcc_handshake.sv
module mcc_handshake
  import midi_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_ready,
  output logic              ready_clr,
  output logic              take,
  output logic [BYTE_W-1:0] byte_q,
  output logic              armed
);

  logic accept;
  assign accept = armed && rx_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b1;
      ready_clr <= 1'b0;
      take      <= 1'b0;
      byte_q    <= '0;
    end else begin
      ready_clr <= 1'b0;
      take      <= 1'b0;
      if (accept) begin
        armed     <= 1'b0;
        ready_clr <= 1'b1;
        take      <= 1'b1;
        byte_q    <= rx_byte;
      end else if (!armed && !rx_ready) begin
        armed <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/mcc_parser.sv
module mcc_parser
  import midi_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [BYTE_W-1:0] byte_q,
  output logic              fire,
  output logic              on_cmd,
  output logic [CHAN_W-1:0] chan,
  output logic [DATA_W-1:0] key,
  output parse_state_t      state
);

  logic status_in;
  assign status_in = is_status(byte_q);
  assign fire = take && !status_in && (state == PS_VEL);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= PS_IDLE;
      on_cmd <= 1'b0;
      chan   <= '0;
      key    <= '0;
    end else if (take) begin
      if (status_in) begin
        if (is_note_cmd(byte_q)) begin
          state  <= PS_KEY;
          on_cmd <= cmd_is_on(byte_q);
          chan   <= byte_q[CHAN_W-1:0];
        end else begin
          state <= PS_IDLE;
        end
      end else begin
        case (state)
          PS_KEY: begin
            key   <= byte_q[DATA_W-1:0];
            state <= PS_VEL;
          end
          PS_VEL:  state <= PS_IDLE;
          default: state <= PS_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/mcc_event_reg.sv
module mcc_event_reg
  import midi_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              on_cmd,
  input  logic [CHAN_W-1:0] chan,
  input  logic [DATA_W-1:0] key,
  input  logic [DATA_W-1:0] vel,
  output logic              ev_valid,
  output logic              ev_on,
  output logic [CHAN_W-1:0] ev_chan,
  output logic [DATA_W-1:0] ev_key,
  output logic [DATA_W-1:0] ev_vel
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_valid <= 1'b0;
      ev_on    <= 1'b0;
      ev_chan  <= '0;
      ev_key   <= '0;
      ev_vel   <= '0;
    end else begin
      ev_valid <= fire;
      if (fire) begin
        ev_on   <= sounding(on_cmd, vel);
        ev_chan <= chan;
        ev_key  <= key;
        ev_vel  <= vel;
      end
    end
  end

endmodule

// File: rtl/midi_capture_ctrl.sv
module midi_capture_ctrl
  import midi_cap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] rx_byte,
  input  logic       rx_ready,
  output logic       ready_clr,
  output logic       ev_valid,
  output logic       ev_on,
  output logic [3:0] ev_chan,
  output logic [6:0] ev_key,
  output logic [6:0] ev_vel
);

  logic              hs_armed;
  logic              hs_take;
  logic [BYTE_W-1:0] hs_byte;
  logic              parse_fire;
  logic              parse_on;
  logic [CHAN_W-1:0] parse_chan;
  logic [DATA_W-1:0] parse_key;
  parse_state_t      parse_state;

  mcc_handshake u_hs (
    .clk       (clk),
    .rst       (rst),
    .rx_byte   (rx_byte),
    .rx_ready  (rx_ready),
    .ready_clr (ready_clr),
    .take      (hs_take),
    .byte_q    (hs_byte),
    .armed     (hs_armed)
  );

  mcc_parser u_parse (
    .clk    (clk),
    .rst    (rst),
    .take   (hs_take),
    .byte_q (hs_byte),
    .fire   (parse_fire),
    .on_cmd (parse_on),
    .chan   (parse_chan),
    .key    (parse_key),
    .state  (parse_state)
  );

  mcc_event_reg u_ev (
    .clk      (clk),
    .rst      (rst),
    .fire     (parse_fire),
    .on_cmd   (parse_on),
    .chan     (parse_chan),
    .key      (parse_key),
    .vel      (hs_byte[DATA_W-1:0]),
    .ev_valid (ev_valid),
    .ev_on    (ev_on),
    .ev_chan  (ev_chan),
    .ev_key   (ev_key),
    .ev_vel   (ev_vel)
  );

endmodule

// File: rtl/mcc_checker.sv
module mcc_checker (
  input logic       clk,
  input logic       rst,
  input logic       rx_ready,
  input logic       ready_clr,
  input logic       armed,
  input logic       ev_valid,
  input logic       ev_on,
  input logic [6:0] ev_vel
);

  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ready_clr |=> !ready_clr); // R2

  AST_CLR_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    ready_clr |-> $past(rx_ready)); // R2

  AST_NO_REFIRE: assert property (@(posedge clk) disable iff (rst)
    (!armed && rx_ready) |=> !ready_clr); // R3

  AST_EV_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ev_valid |=> !ev_valid); // R4

  AST_EV_PACED: assert property (@(posedge clk) disable iff (rst)
    ev_valid |-> $past(ready_clr)); // R4

  AST_ZERO_VEL_OFF: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_vel == 7'd0) |-> !ev_on); // R6

endmodule

bind midi_capture_ctrl mcc_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .rx_ready  (rx_ready),
  .ready_clr (ready_clr),
  .armed     (hs_armed),
  .ev_valid  (ev_valid),
  .ev_on     (ev_on),
  .ev_vel    (ev_vel)
);

// File: tb/test_midi_capture_ctrl.sv
module test_midi_capture_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] rx_byte = 8'h00;
  logic       rx_ready = 1'b0;
  logic       ready_clr;
  logic       ev_valid;
  logic       ev_on;
  logic [3:0] ev_chan;
  logic [6:0] ev_key;
  logic [6:0] ev_vel;

  int n_cmp = 0;
  int n_bad = 0;

  // bench model of the parser: 0 idle, 1 key expected, 2 velocity expected
  int         m_st = 0;
  logic       m_on = 1'b0;
  logic [3:0] m_ch = 4'd0;
  logic [6:0] m_key = 7'd0;

  always #5 clk = ~clk;

  midi_capture_ctrl i_midi_capture_ctrl (
    .clk(clk), .rst(rst), .rx_byte(rx_byte), .rx_ready(rx_ready),
    .ready_clr(ready_clr), .ev_valid(ev_valid), .ev_on(ev_on),
    .ev_chan(ev_chan), .ev_key(ev_key), .ev_vel(ev_vel)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // send one byte, flag held 'hold' extra cycles beyond the strobe response
  task automatic send(input logic [7:0] b, input int hold, input string req);
    logic       x_ev;
    logic       x_on;
    logic [3:0] x_ch;
    logic [6:0] x_key;
    x_ev = 1'b0;
    x_on = 1'b0;
    x_ch = m_ch;
    x_key = m_key;
    if (b[7]) begin
      if (b[7:4] == 4'h9 || b[7:4] == 4'h8) begin
        m_st = 1; m_on = (b[7:4] == 4'h9); m_ch = b[3:0];
      end else m_st = 0;
    end else if (m_st == 1) begin
      m_key = b[6:0]; m_st = 2;
    end else if (m_st == 2) begin
      x_ev = 1'b1; x_on = m_on && (b[6:0] != 0); x_ch = m_ch; x_key = m_key; m_st = 0;
    end
    @(negedge clk);
    rx_byte = b;
    rx_ready = 1'b1;
    @(negedge clk);
    check({"R2 strobe ", req}, int'(ready_clr), 1);
    @(negedge clk);
    check({"R2 strobe width ", req}, int'(ready_clr), 0);
    check({"R4 event valid ", req}, int'(ev_valid), int'(x_ev));
    if (x_ev) begin
      check({"R5 on/off ", req}, int'(ev_on), int'(x_on));
      check({"R5 channel ", req}, int'(ev_chan), int'(x_ch));
      check({"R4 key ", req}, int'(ev_key), int'(x_key));
      check({"R4 velocity ", req}, int'(ev_vel), int'(b[6:0]));
    end
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check({"R3 no refire ", req}, int'(ready_clr), 0);
      check({"R4 event single ", req}, int'(ev_valid), 0);
    end
    rx_ready = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset clr", int'(ready_clr), 0);
    check("R1 reset valid", int'(ev_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset clr", int'(ready_clr), 0);
    check("R1 after reset valid", int'(ev_valid), 0);

    // R4 R5 sweep: all channels, both commands, varied keys/velocities/holds
    for (int ch = 0; ch < 16; ch++) begin
      for (int cmd = 0; cmd < 2; cmd++) begin
        send({(cmd == 1) ? 4'h9 : 4'h8, 4'(ch)}, ch % 4, "R5 status");
        send(8'((ch * 7 + cmd * 37) % 128), (ch + 1) % 4, "R4 key");
        send(8'((ch * 13 + cmd * 50 + 1) % 128), (ch + 2) % 4, "R4 vel");
      end
    end

    // R6 note-on at zero velocity, and at 127
    send(8'h95, 0, "R6 status");
    send(8'h3C, 2, "R6 key");
    send(8'h00, 1, "R6 zero vel");
    send(8'h9F, 0, "R6 status");
    send(8'h7F, 0, "R6 key");
    send(8'h7F, 3, "R6 full vel");

    // R7 status arrives mid-message
    send(8'h92, 0, "R7 status");
    send(8'h40, 0, "R7 key");
    send(8'h83, 1, "R7 restart");
    send(8'h21, 0, "R7 key");
    send(8'h11, 0, "R7 vel");
    send(8'h94, 0, "R7 status");
    send(8'h9A, 0, "R7 restart at key");
    send(8'h05, 0, "R7 key");
    send(8'h66, 0, "R7 vel");

    // R8 foreign status then data bytes
    for (int s = 10; s < 16; s++) begin
      send({4'(s), 4'h2}, s % 3, "R8 foreign status");
      send(8'h30, 0, "R8 data ignored");
      send(8'h31, 0, "R8 data ignored");
      send(8'h32, 0, "R8 data ignored");
    end
    send(8'h91, 0, "R8 note after foreign");
    send(8'h10, 0, "R8 key");
    send(8'h20, 0, "R8 vel");

    // R9 stray data in idle
    send(8'h00, 0, "R9 idle data");
    send(8'h7F, 2, "R9 idle data");
    send(8'h45, 0, "R9 idle data");

    // R10 reset mid-message with flag held high across reset
    send(8'h97, 0, "R10 status");
    send(8'h22, 0, "R10 key");
    @(negedge clk);
    rx_byte = 8'h55;
    rx_ready = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset mid-message clr", int'(ready_clr), 0);
    rst = 1'b0;
    m_st = 0;
    @(negedge clk);
    check("R10 strobe after reset", int'(ready_clr), 1);
    @(negedge clk);
    check("R10 strobe width", int'(ready_clr), 0);
    check("R10 discarded message", int'(ev_valid), 0);
    rx_ready = 1'b0;
    @(negedge clk);
    send(8'h33, 0, "R10 data after reset");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule